// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block is the interrupt logic for one bank of general-purpose input pins. Each pin is brought into the clock domain through two flops. Three per-pin configuration vectors then decide what counts as an event on that pin: a sense vector picks level or edge detection, a polarity vector picks active-high or active-low (for an edge, rising or falling), and a dual-edge vector makes an edge-sensing pin fire on every transition.

Events are latched into a sticky pending vector. Software clears bits in that vector by writing ones. A mask vector gates which pending bits reach the single interrupt line. Software clears mask bits through an unmask port and sets them through a mask port; both ports take ones and leave zero bits alone. The interrupt line is registered.

Access goes through a plain register port: address, write data, write strobe and combinational read data. Reset is synchronous and active high.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, sense (addr 0) reads all ones except where the `SENSE_RESET` parameter says otherwise. Polarity (addr 1), dual-edge (addr 2) and pending (addr 6) read zero. Mask (addr 5) reads all ones, and `irq` is 0.
- R2: Sense, polarity and dual-edge read back what was last written. Addresses 3, 4 and 7 read zero. A write to the mask address 5 has no effect.
- R3: A pin whose sense bit is 0 is level sensitive. It sets its pending bit while its synchronized level equals its polarity bit (1 = high active, 0 = low active).
- R4: While the active level persists on a level-sensitive pin, a clear of its pending bit does not hold: the bit is set again on the next clock.
- R5: A pin whose sense bit is 1 and whose dual-edge bit is 0 sets its pending bit only on a rising edge when polarity is 1, or only on a falling edge when polarity is 0.
- R6: A pin whose sense bit is 1 and whose dual-edge bit is 1 sets its pending bit on both edges, whatever its polarity bit is.
- R7: Writing address 6 clears each pending bit whose write-data bit is 1 and leaves the others unchanged. Pending bits stay set until they are cleared this way.
- R8: Writing address 3 clears the mask bit of every pin whose write-data bit is 1, so that pin is unmasked. Zero bits keep their setting.
- R9: Writing address 4 sets the mask bit of every pin whose write-data bit is 1, so that pin is masked. Zero bits keep their setting.
- R10: `irq` is the OR over all pins of pending AND NOT mask, registered. It rises one clock after an unmasked pending bit exists.
- R11: When an event and a clear write hit the same pending bit on the same clock, the bit ends up set.
- R12: A pin change applied before clock edge k shows in the pending vector after edge k+2 (two synchronizer flops, then the pending flop), and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pins | input | 32 | Raw asynchronous pin inputs |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A corrupted pending bit or mask bit is easy to see from outside. The pending and mask vectors can be read back directly. A stray unmasked pending bit also drives `irq` one clock later. A wrong synchronizer depth or a wrong edge history moves the pending bit off its expected cycle, or sets it on the wrong transition. Polarity and dual-edge faults show up within three clocks of a single pin transition.

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int          WIDTH       = 32,
  parameter int          AW          = 3,
  parameter logic [31:0] SENSE_RESET = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pins,
  output logic             irq
);
  localparam logic [AW-1:0] A_SENSE = AW'(0);
  localparam logic [AW-1:0] A_POL   = AW'(1);
  localparam logic [AW-1:0] A_DUAL  = AW'(2);
  localparam logic [AW-1:0] A_UNMSK = AW'(3);
  localparam logic [AW-1:0] A_MSK   = AW'(4);
  localparam logic [AW-1:0] A_MASKV = AW'(5);
  localparam logic [AW-1:0] A_PEND  = AW'(6);

  logic [WIDTH-1:0] sync1, sync2, prev;
  logic [WIDTH-1:0] sense, pol, dual, mask, pend;
  logic [WIDTH-1:0] rise, fall, edge_hit, level_hit, event_v, clr_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise      = sync2 & ~prev;
  assign fall      = ~sync2 & prev;
  assign edge_hit  = (dual & (rise | fall)) | (~dual & ((pol & rise) | (~pol & fall)));
  assign level_hit = ~(sync2 ^ pol);
  assign event_v   = (sense & edge_hit) | (~sense & level_hit);
  assign clr_v     = (we && addr == A_PEND) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense <= SENSE_RESET[WIDTH-1:0];
      pol   <= '0;
      dual  <= '0;
      mask  <= '1;
      pend  <= '0;
      irq   <= 1'b0;
    end else begin
      if (we && addr == A_SENSE) sense <= wdata;
      if (we && addr == A_POL)   pol   <= wdata;
      if (we && addr == A_DUAL)  dual  <= wdata;
      if (we && addr == A_UNMSK) mask  <= mask & ~wdata;
      if (we && addr == A_MSK)   mask  <= mask | wdata;
      pend <= (pend & ~clr_v) | event_v;
      irq  <= |(pend & ~mask);
    end
  end

  always_comb begin
    case (addr)
      A_SENSE: rdata = sense;
      A_POL:   rdata = pol;
      A_DUAL:  rdata = dual;
      A_MASKV: rdata = mask;
      A_PEND:  rdata = pend;
      default: rdata = '0;
    endcase
  end
endmodule

module gpio_irq_unit_props #(
  parameter int WIDTH = 32,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             we,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] mask,
  input logic [WIDTH-1:0] pend,
  input logic             irq
);
  p_unmask_r8: assert property (@(posedge clk) disable iff (rst)
    (we && addr == AW'(3)) |=> ((mask & $past(wdata)) == '0));

  p_mask_set_r9: assert property (@(posedge clk) disable iff (rst)
    (we && addr == AW'(4)) |=> ((mask & $past(wdata)) == $past(wdata)));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(we && (addr == AW'(3) || addr == AW'(4))) |=> $stable(mask));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == AW'(6)) |=> ((pend & $past(pend)) == $past(pend)));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pend != '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_props #(.WIDTH(WIDTH), .AW(AW)) u_props (
  .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
  .mask(mask), .pend(pend), .irq(irq)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we  = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        irq;
  int total = 0;
  int bad   = 0;

  gpio_irq_unit uut (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pins(pins), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  // fields: {sense, pol, dual, v0, v1, expected pending}
  localparam logic [5:0] VEC [11] = '{
    6'b110_01_1, // R5 rising edge fires
    6'b110_10_0, // R5 falling ignored when polarity high
    6'b100_10_1, // R5 falling edge fires
    6'b100_01_0, // R5 rising ignored when polarity low
    6'b101_01_1, // R6 dual, rise, polarity low
    6'b111_10_1, // R6 dual, fall, polarity high
    6'b101_10_1, // R6 dual, fall, polarity low
    6'b010_11_1, // R3 level high active, R4 re-set after clear
    6'b010_00_0, // R3 level high inactive
    6'b000_00_1, // R3 level low active
    6'b000_11_0  // R3 level low inactive
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rd(3'd0, v); chk("R1 sense", v, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R1 pol", v, 32'h0);
    rd(3'd2, v); chk("R1 dual", v, 32'h0);
    rd(3'd6, v); chk("R1 pending", v, 32'h0);
    rd(3'd5, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 readback and ignored addresses
    wr(3'd1, 32'hA5A5_0F0F); rd(3'd1, v); chk("R2 pol readback", v, 32'hA5A5_0F0F);
    wr(3'd2, 32'h3C3C_F0F0); rd(3'd2, v); chk("R2 dual readback", v, 32'h3C3C_F0F0);
    rd(3'd3, v); chk("R2 addr3 reads zero", v, 32'h0);
    rd(3'd4, v); chk("R2 addr4 reads zero", v, 32'h0);
    rd(3'd7, v); chk("R2 addr7 reads zero", v, 32'h0);
    wr(3'd5, 32'h0); rd(3'd5, v); chk("R2 mask write ignored", v, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0); wr(3'd2, 32'h0);

    // table walk on pin 0
    for (int i = 0; i < 11; i++) begin
      logic [5:0] e;
      e = VEC[i];
      wr(3'd0, {31'h7FFF_FFFF, e[5]});
      wr(3'd1, {31'h0, e[4]});
      wr(3'd2, {31'h0, e[3]});
      pins[0] = e[2];
      idle(5);
      wr(3'd6, 32'hFFFF_FFFF);
      pins[0] = e[1];
      idle(5);
      rd(3'd6, v);
      chk($sformatf("R3/R4/R5/R6 vector %0d", i), v, {31'h0, e[0]});
    end

    // back to falling-edge on all, pins low, clear pending
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
    pins = '0;
    idle(5);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R7 all cleared", v, 32'h0);

    // R12 latency: rising edge on pin 4, polarity high
    wr(3'd1, 32'h0000_0010);
    idle(3);
    pins[4] = 1'b1;            // before edge k
    @(negedge clk);            // after k
    @(negedge clk);            // after k+1
    rd(3'd6, v); chk("R12 not after k+1", v, 32'h0);
    @(negedge clk);            // after k+2
    rd(3'd6, v); chk("R12 set after k+2", v, 32'h0000_0010);

    // R7 sticky and partial clear
    pins[4] = 1'b0;            // falling: ignored with polarity high
    wr(3'd1, 32'h0000_0030);
    pins[5] = 1'b1;
    idle(5);
    rd(3'd6, v); chk("R7 two pending", v, 32'h0000_0030);
    wr(3'd6, 32'h0000_0020);
    rd(3'd6, v); chk("R7 zero bits untouched", v, 32'h0000_0010);

    // R11 event wins over clear in the same cycle (rising edge on pin 6)
    wr(3'd1, 32'h0000_0070);
    idle(2);
    pins[6] = 1'b1;            // before edge k
    @(negedge clk);            // after k
    @(negedge clk);            // after k+1: event visible, write lands at k+2
    we = 1'b1; addr = 3'd6; wdata = 32'h0000_0050;
    @(negedge clk);
    we = 1'b0;
    rd(3'd6, v); chk("R11 event beats clear", v, 32'h0000_0040);

    // R8 / R9 mask and R10 irq
    chk("R10 irq low while masked", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h0000_000F);
    rd(3'd5, v); chk("R8 unmask low nibble", v, 32'hFFFF_FFF0);
    chk("R10 irq low, no unmasked pending", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h0000_0040);
    chk("R10 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq one clock later", {31'b0, irq}, 32'h1);
    rd(3'd5, v); chk("R8 zero bits kept", v, 32'hFFFF_FFB0);
    wr(3'd4, 32'h0000_0043);
    rd(3'd5, v); chk("R9 mask bits set", v, 32'hFFFF_FFF3);
    @(negedge clk);
    chk("R10 irq drops when masked", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h0000_0040);
    idle(1);
    chk("R10 irq back", {31'b0, irq}, 32'h1);
    wr(3'd6, 32'h0000_0040);
    idle(1);
    chk("R7 clear drops irq", {31'b0, irq}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule